// File: doc/BRIEF.md
# Flash Read-Path Mode Responder

This block answers reads on behalf of a parallel NOR flash model. A separate command sequencer tracks the write-cycle protocol and presents its current command code. On each read strobe the responder uses that code to choose a data source and registers the result. The source is one of four: the storage array, the identification words, the program/erase status byte, or the external query table.

The storage array and the query table are outside the block. The responder drives one byte address per data lane toward the array, and an index toward the query table. It then assembles what comes back. Status reads are destructive. Each one returns the current byte and emits a one-cycle request, and the sequencer answers that request by inverting bit 6, so a polling host sees that bit alternate while an operation is in progress.

Top module: `flash_rd_resp`

## Requirements
- R1: With command code 0x00 (idle), 0x80 (erase setup) or any code not named in R3, R5 or R7, a read returns array data as described in R2.
- R2: An array read at byte address A returns byte A in bits 7:0, A+1 in 15:8, A+2 in 23:16 and A+3 in 31:24, with addresses wrapping modulo the array size. Width code 0 takes 1 byte, code 1 takes 2 bytes, and codes 2 and 3 take 4 bytes. Bits above the bytes taken read as zero.
- R3: With code 0x90 (autoselect), mode offset 0 returns ID word 0, offset 1 returns ID word 1, and offset 2 returns 0x0000.
- R4: In autoselect, offsets 0x0E and 0x0F return ID words 2 and 3, unless the word is 0xFFFF, in which case array data is returned. Every other offset returns array data.
- R5: With code 0xA0, 0x10 or 0x30, a read returns the status byte in bits 7:0 with zeros above. toggle_req is high for exactly the cycle in which that result is valid.
- R6: toggle_req is never high except on the result of a status read.
- R7: With code 0x98 (query), cfi_idx equals the mode offset. A read returns cfi_data in bits 7:0 when the offset is at most the table-length parameter, and returns 0 otherwise.
- R8: The mode offset is address bits 7:0 shifted right by 0, 1 or 2 for devices 1, 2 or 4 bytes wide.
- R9: rd_valid and rd_data update on the clock edge that samples rd_stb high. rd_data holds its value while rd_stb is low.
- R10: After reset, rd_data is 0 and rd_valid and toggle_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_stb | input | 1 | Read request, one cycle |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_width | input | 2 | Access width code (0: 1 B, 1: 2 B, 2/3: 4 B) |
| cmd_code | input | 8 | Current command code from the sequencer |
| status_byte | input | 8 | Current status byte |
| id_word0 | input | 16 | Identification word 0 |
| id_word1 | input | 16 | Identification word 1 |
| id_word2 | input | 16 | Extended identification word 2 (0xFFFF = absent) |
| id_word3 | input | 16 | Extended identification word 3 (0xFFFF = absent) |
| cfi_idx | output | 8 | Query table index |
| cfi_data | input | 8 | Query table entry at cfi_idx |
| lane_addr | output | 4*ADDR_W | Array byte address per lane, lane 0 lowest |
| lane_data | input | 32 | Array byte per lane, lane k in bits 8k+7:8k |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | rd_data was loaded on the last edge |
| toggle_req | output | 1 | Request to invert status bit 6 |

## Verification
The bench builds the block as a 16-bit device (offset shift of 1) with a 10-bit array address. This keeps all 1024 byte addresses within reach for each width code, including the wrap at the top of the array. The 8-bit address window then spans mode offsets 0 to 127, so one pass covers every autoselect slot and the query table both inside and past its 0x52 length. The bench computes the array and table contents arithmetically and serves them itself, which lets it derive each expected word independently.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;

  typedef enum logic [1:0] {
    M_ARRAY  = 2'd0,
    M_IDENT  = 2'd1,
    M_STATUS = 2'd2,
    M_QUERY  = 2'd3
  } rd_mode_e;

  localparam logic [7:0] CMD_IDLE        = 8'h00;
  localparam logic [7:0] CMD_ERASE_SETUP = 8'h80;
  localparam logic [7:0] CMD_AUTOSEL     = 8'h90;
  localparam logic [7:0] CMD_PROGRAM     = 8'hA0;
  localparam logic [7:0] CMD_CHIP_ERASE  = 8'h10;
  localparam logic [7:0] CMD_SECT_ERASE  = 8'h30;
  localparam logic [7:0] CMD_QUERY       = 8'h98;

  localparam logic [15:0] ID_ABSENT = 16'hFFFF;

  // number of bytes taken for a width code
  function automatic logic [2:0] width_bytes(input logic [1:0] code);
    case (code)
      2'd0:    width_bytes = 3'd1;
      2'd1:    width_bytes = 3'd2;
      default: width_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/frr_mode_decode.sv
module frr_mode_decode
  import flash_rd_pkg::*;
#(
  parameter int DEV_BYTES = 2
) (
  input  logic [7:0] cmd_code,
  input  logic [7:0] addr_lo,
  output rd_mode_e   mode,
  output logic [7:0] offs
);
  localparam int SHIFT = (DEV_BYTES == 4) ? 2 : ((DEV_BYTES == 2) ? 1 : 0);

  always_comb begin
    case (cmd_code)
      CMD_AUTOSEL:                              mode = M_IDENT;
      CMD_PROGRAM, CMD_CHIP_ERASE, CMD_SECT_ERASE: mode = M_STATUS;
      CMD_QUERY:                                mode = M_QUERY;
      default:                                  mode = M_ARRAY;
    endcase
  end

  assign offs = addr_lo >> SHIFT;

endmodule

// File: rtl/frr_array_gather.sv
module frr_array_gather
  import flash_rd_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4
) (
  input  logic [ADDR_W-1:0]       rd_addr,
  input  logic [1:0]              rd_width,
  output logic [LANES*ADDR_W-1:0] lane_addr,
  input  logic [LANES*8-1:0]      lane_data,
  output logic [LANES*8-1:0]      arr_word
);
  logic [2:0] nbytes;
  assign nbytes = width_bytes(rd_width);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic lane_en;
    assign lane_addr[k*ADDR_W +: ADDR_W] = rd_addr + ADDR_W'(k);
    assign lane_en = (3'(k) < nbytes);
    assign arr_word[k*8 +: 8] = lane_en ? lane_data[k*8 +: 8] : 8'h00;
  end

endmodule

// File: rtl/frr_mode_mux.sv
module frr_mode_mux
  import flash_rd_pkg::*;
#(
  parameter int          DATA_W  = 32,
  parameter int          ID_W    = 16,
  parameter logic [7:0]  CFI_LEN = 8'h52
) (
  input  rd_mode_e          mode,
  input  logic [7:0]        offs,
  input  logic [DATA_W-1:0] arr_word,
  input  logic [7:0]        status_byte,
  input  logic [ID_W-1:0]   id_word0,
  input  logic [ID_W-1:0]   id_word1,
  input  logic [ID_W-1:0]   id_word2,
  input  logic [ID_W-1:0]   id_word3,
  input  logic [7:0]        cfi_data,
  output logic [DATA_W-1:0] data_sel,
  output logic              toggle_sel
);
  logic [DATA_W-1:0] ident_val;
  logic [DATA_W-1:0] query_val;

  always_comb begin
    case (offs)
      8'h00:   ident_val = DATA_W'(id_word0);
      8'h01:   ident_val = DATA_W'(id_word1);
      8'h02:   ident_val = '0;
      8'h0E:   ident_val = (id_word2 == ID_ABSENT) ? arr_word : DATA_W'(id_word2);
      8'h0F:   ident_val = (id_word3 == ID_ABSENT) ? arr_word : DATA_W'(id_word3);
      default: ident_val = arr_word;
    endcase
  end

  assign query_val = (offs > CFI_LEN) ? '0 : DATA_W'(cfi_data);

  always_comb begin
    toggle_sel = 1'b0;
    case (mode)
      M_IDENT:  data_sel = ident_val;
      M_STATUS: begin
        data_sel   = DATA_W'(status_byte);
        toggle_sel = 1'b1;
      end
      M_QUERY:  data_sel = query_val;
      default:  data_sel = arr_word;
    endcase
  end

endmodule

// File: rtl/flash_rd_resp.sv
module flash_rd_resp
  import flash_rd_pkg::*;
#(
  parameter int         ADDR_W    = 10,
  parameter int         DEV_BYTES = 2,
  parameter logic [7:0] CFI_LEN   = 8'h52
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_stb,
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic [1:0]          rd_width,
  input  logic [7:0]          cmd_code,
  input  logic [7:0]          status_byte,
  input  logic [15:0]         id_word0,
  input  logic [15:0]         id_word1,
  input  logic [15:0]         id_word2,
  input  logic [15:0]         id_word3,
  output logic [7:0]          cfi_idx,
  input  logic [7:0]          cfi_data,
  output logic [4*ADDR_W-1:0] lane_addr,
  input  logic [31:0]         lane_data,
  output logic [31:0]         rd_data,
  output logic                rd_valid,
  output logic                toggle_req
);
  localparam int LANES  = 4;
  localparam int DATA_W = LANES * 8;

  rd_mode_e          mode;
  logic [7:0]        offs;
  logic [DATA_W-1:0] arr_word;
  logic [DATA_W-1:0] data_sel;
  logic              toggle_sel;

  logic [DATA_W-1:0] data_q, data_d;
  logic              valid_q, valid_d;
  logic              tog_q, tog_d;

  frr_mode_decode #(.DEV_BYTES(DEV_BYTES)) u_decode (
    .cmd_code (cmd_code),
    .addr_lo  (rd_addr[7:0]),
    .mode     (mode),
    .offs     (offs)
  );

  frr_array_gather #(.ADDR_W(ADDR_W), .LANES(LANES)) u_gather (
    .rd_addr   (rd_addr),
    .rd_width  (rd_width),
    .lane_addr (lane_addr),
    .lane_data (lane_data),
    .arr_word  (arr_word)
  );

  frr_mode_mux #(.DATA_W(DATA_W), .ID_W(16), .CFI_LEN(CFI_LEN)) u_mux (
    .mode        (mode),
    .offs        (offs),
    .arr_word    (arr_word),
    .status_byte (status_byte),
    .id_word0    (id_word0),
    .id_word1    (id_word1),
    .id_word2    (id_word2),
    .id_word3    (id_word3),
    .cfi_data    (cfi_data),
    .data_sel    (data_sel),
    .toggle_sel  (toggle_sel)
  );

  assign cfi_idx = offs;

  // next state
  always_comb begin
    data_d  = data_q;
    valid_d = 1'b0;
    tog_d   = 1'b0;
    if (rd_stb) begin
      data_d  = data_sel;
      valid_d = 1'b1;
      tog_d   = toggle_sel;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      tog_q   <= 1'b0;
    end else begin
      data_q  <= data_d;
      valid_q <= valid_d;
      tog_q   <= tog_d;
    end
  end

  assign rd_data    = data_q;
  assign rd_valid   = valid_q;
  assign toggle_req = tog_q;

  p_valid_after_stb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> rd_valid);

  p_no_valid_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> !rd_valid);

  p_hold_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rd_data));

  p_toggle_with_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    toggle_req |-> rd_valid);

  p_status_toggles_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && mode == M_STATUS) |=> toggle_req);

  p_query_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && mode == M_QUERY && offs > CFI_LEN) |=> (rd_data == '0));

  p_byte_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && mode == M_ARRAY && rd_width == 2'd0) |=> (rd_data[31:8] == '0));

endmodule

// File: tb/flash_rd_resp_tb.sv
module flash_rd_resp_tb;
  localparam int AW    = 10;
  localparam int ASIZE = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          rd_stb;
  logic [AW-1:0] rd_addr;
  logic [1:0]    rd_width;
  logic [7:0]    cmd_code;
  logic [7:0]    status_byte;
  logic [15:0]   id0, id1, id2, id3;
  logic [7:0]    cfi_idx, cfi_data;
  logic [4*AW-1:0] lane_addr;
  logic [31:0]   lane_data;
  logic [31:0]   rd_data;
  logic          rd_valid, toggle_req;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  flash_rd_resp #(.ADDR_W(AW), .DEV_BYTES(2), .CFI_LEN(8'h52)) u_dut (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_addr(rd_addr),
    .rd_width(rd_width), .cmd_code(cmd_code), .status_byte(status_byte),
    .id_word0(id0), .id_word1(id1), .id_word2(id2), .id_word3(id3),
    .cfi_idx(cfi_idx), .cfi_data(cfi_data), .lane_addr(lane_addr),
    .lane_data(lane_data), .rd_data(rd_data), .rd_valid(rd_valid),
    .toggle_req(toggle_req)
  );

  function automatic logic [7:0] arr_byte(int a);
    return 8'((a * 37 + 11) ^ (a >> 3));
  endfunction

  function automatic logic [7:0] cfi_byte(int i);
    if (i == 16) return 8'h51;
    if (i == 17) return 8'h52;
    if (i == 18) return 8'h59;
    return 8'((i * 5 + 1) ^ 8'h3C);
  endfunction

  // external storage and query table
  always_comb begin
    for (int k = 0; k < 4; k++)
      lane_data[k*8 +: 8] = arr_byte(int'(lane_addr[k*AW +: AW]));
    cfi_data = cfi_byte(int'(cfi_idx));
  end

  function automatic logic [31:0] exp_array(int a, int w);
    int n;
    logic [31:0] v;
    n = (w == 0) ? 1 : ((w == 1) ? 2 : 4);
    v = '0;
    for (int k = 0; k < n; k++)
      v[k*8 +: 8] = arr_byte((a + k) % ASIZE);
    return v;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic do_read(int a, int w, logic [7:0] cmd);
    @(negedge clk);
    rd_addr  = AW'(a);
    rd_width = 2'(w);
    cmd_code = cmd;
    rd_stb   = 1'b1;
    @(negedge clk);
    rd_stb   = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; rd_stb = 1'b0; rd_addr = '0; rd_width = '0;
    cmd_code = 8'h00; status_byte = 8'h00;
    id0 = 16'h0001; id1 = 16'h227E; id2 = 16'h2210; id3 = 16'h2201;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 data", rd_data, 32'h0);
    chk("R10 valid", {31'b0, rd_valid}, 32'h0);
    chk("R10 toggle", {31'b0, toggle_req}, 32'h0);
    rst_n = 1'b1;

    // R2/R1 array sweep, all widths and addresses, idle code
    for (int w = 0; w < 4; w++)
      for (int a = 0; a < ASIZE; a++) begin
        do_read(a, w, 8'h00);
        chk("R2 array", rd_data, exp_array(a, w));
        chk("R6 no toggle on array", {31'b0, toggle_req}, 32'h0);
      end
    // R1 erase setup and unknown codes
    for (int a = 0; a < 256; a++) begin
      do_read(a, 2, 8'h80);
      chk("R1 erase setup", rd_data, exp_array(a, 2));
      do_read(a, 1, 8'(a + 8'h41) == 8'h90 ? 8'h55 : 8'(a * 3 + 8'h41) == 8'h98 ? 8'h55 : 8'h77);
      chk("R1 unknown code", rd_data, exp_array(a, 1));
    end

    // R9 hold and valid drop
    do_read(5, 2, 8'h00);
    repeat (3) @(negedge clk);
    chk("R9 hold", rd_data, exp_array(5, 2));
    chk("R9 valid low", {31'b0, rd_valid}, 32'h0);

    // R3/R4/R8 autoselect, present extended IDs then absent
    for (int pass = 0; pass < 2; pass++) begin
      if (pass == 1) begin id2 = 16'hFFFF; id3 = 16'hFFFF; end
      for (int a = 0; a < 256; a++) begin
        int o;
        logic [31:0] e;
        o = a >> 1;
        e = exp_array(a, 2);
        if (o == 0) e = {16'h0, id0};
        else if (o == 1) e = {16'h0, id1};
        else if (o == 2) e = 32'h0;
        else if (o == 14 && id2 != 16'hFFFF) e = {16'h0, id2};
        else if (o == 15 && id3 != 16'hFFFF) e = {16'h0, id3};
        do_read(a, 2, 8'h90);
        chk((o < 3) ? "R3 ident" : "R4 ident/fallback R8", rd_data, e);
        chk("R6 no toggle on ident", {31'b0, toggle_req}, 32'h0);
      end
    end

    // R7/R8 query table
    for (int a = 0; a < 256; a++) begin
      int o;
      o = a >> 1;
      do_read(a, 0, 8'h98);
      chk("R7 query", rd_data, (o > 8'h52) ? 32'h0 : {24'h0, cfi_byte(o)});
      chk("R6 no toggle on query", {31'b0, toggle_req}, 32'h0);
    end

    // R5 status polling with the sequencer model inverting bit 6
    begin
      logic [7:0] cmds [3];
      cmds[0] = 8'hA0; cmds[1] = 8'h10; cmds[2] = 8'h30;
      for (int c = 0; c < 3; c++) begin
        status_byte = 8'h80 >> c;
        for (int i = 0; i < 6; i++) begin
          logic [7:0] e;
          e = (8'h80 >> c) ^ ((i % 2 == 1) ? 8'h40 : 8'h00);
          do_read(i * 3, 2, cmds[c]);
          chk("R5 status", rd_data, {24'h0, e});
          chk("R5 toggle pulse", {31'b0, toggle_req}, 32'h1);
          if (toggle_req) status_byte = status_byte ^ 8'h40;
          @(negedge clk);
          chk("R6 pulse one cycle", {31'b0, toggle_req}, 32'h0);
        end
      end
    end

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule